// File: doc/BRIEF.md
# Nonvolatile Erase/Program Sequencer

This block sits behind the serial command slave of an in-system programming port. It turns the programmer's load, bulk-erase and begin-programming commands into timed erase and write phases for a nonvolatile store. Each phase lasts a fixed number of system clocks, derived from the clock rate and the cell cycle time in microseconds. The slave hands over one decoded 6-bit command per `cmd_valid` strobe, together with the 14-bit word for load commands. A neighbouring counter supplies the current address. Addresses with the top bit set lie in configuration space. Offsets 0 to 15 of that space form the test/ID window, and offset 7 is the configuration word.

The sequencer latches the most recent load and its target: program space, configuration space or data memory. It holds a pending bulk-erase request. It derives the code-protect state from the last configuration word it wrote. It also follows the multi-step unlock handshake, which wipes the arrays and then drops protection. While a phase runs, the operation's address, data, target and erase scope are held steady at the outputs. The surrounding storage model applies them.

Top module: `nv_prog_sequencer`

## Requirements
- R1: After reset, `busy`, `erase_en`, `write_en` and `protected_o` are all 0.
- R2: A begin command (0x08 erase-then-write, 0x18 write-only) is carried out only if a load (0x00 config, 0x02 program, 0x03 data) was accepted after the previous begin. Otherwise it has no effect.
- R3: Begin 0x08 raises `erase_en` for exactly TICKS cycles with `erase_scope`=0 (single word), then `write_en` for exactly TICKS cycles. `nv_addr` carries the current address and `nv_wdata` the loaded word, and both are stable for the whole operation.
- R4: Begin 0x18 raises only `write_en`, for exactly TICKS cycles, with the loaded word and the current address.
- R5: When the load was a data-memory load (0x03), `mem_is_data`=1. `nv_wdata` then carries only the low 8 bits of the loaded word (upper bits 0), and `nv_addr` carries only the low 6 address bits.
- R6: Bulk-erase commands (0x09 program, 0x0B data) only arm an erase. The next valid begin performs an erase of TICKS cycles with `erase_scope`=1 (whole array) and no write phase, and that consumes the arm.
- R7: A program bulk erase (0x09) issued while the address is in the test/ID window gives `erase_scope`=2: user plus test memory, never the configuration word.
- R8: At the end of a write to the configuration word, `protected_o` becomes 1 if any of bits 13..4 of the written word is 0. If bits 13..4 are all 1, it becomes 0.
- R9: While `protected_o`=1, bulk-erase commands 0x09 and 0x0B arm nothing, so the next begin performs an ordinary word operation.
- R10: While `protected_o`=1, a begin whose target is data memory or program space below the configuration base is ignored. Writes into configuration space proceed.
- R11: The unlock handshake is: a config load with bit 4 set, then command 0x01 at the configuration word, then 0x07, then a begin. The begin runs an erase of TICKS cycles with `erase_scope`=3 (all program and data memory) and no write, and protection stays set. A following 0x01 and 0x07 then clear `protected_o`.
- R12: Any command that arrives while `busy`=1 is ignored: loads, bulk erases and begins alike.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cmd_valid | input | 1 | One-cycle strobe: a decoded command is present |
| cmd_code | input | 6 | Command code |
| cmd_data | input | 14 | Data word accompanying load commands |
| cur_addr | input | 14 | Current address from the address counter |
| busy | output | 1 | An erase or write phase is in progress |
| erase_en | output | 1 | Erase phase active |
| write_en | output | 1 | Write phase active |
| mem_is_data | output | 1 | Operation targets data memory |
| erase_scope | output | 2 | 0 word, 1 whole array, 2 user plus test, 3 all memory |
| nv_addr | output | 14 | Operation address |
| nv_wdata | output | 14 | Word to be written |
| protected_o | output | 1 | Code protection currently active |

## Verification
A lost or stale load flag shows at the very next begin: `busy` either rises when it must not or fails to rise one cycle after the strobe. A wrong arm or unlock step shows as a wrong `erase_scope`, or as a write phase where none belongs, on the first cycle of the following operation. Phase-timer errors show as an enable that drops before or after TICKS cycles. A protection bit computed from the wrong field appears on `protected_o` at the edge that ends the configuration write, and the next bulk erase or user write then behaves wrongly.

// File: rtl/nvseq_pkg.sv
`timescale 1ns/1ps
package nvseq_pkg;

    localparam int CMD_W = 6;

    localparam logic [CMD_W-1:0] C_LD_CFG    = 6'h00;
    localparam logic [CMD_W-1:0] C_UNLK_A    = 6'h01;
    localparam logic [CMD_W-1:0] C_LD_PROG   = 6'h02;
    localparam logic [CMD_W-1:0] C_LD_DATA   = 6'h03;
    localparam logic [CMD_W-1:0] C_RD_PROG   = 6'h04;
    localparam logic [CMD_W-1:0] C_RD_DATA   = 6'h05;
    localparam logic [CMD_W-1:0] C_INC       = 6'h06;
    localparam logic [CMD_W-1:0] C_UNLK_B    = 6'h07;
    localparam logic [CMD_W-1:0] C_BEGIN_EW  = 6'h08;
    localparam logic [CMD_W-1:0] C_BULK_PROG = 6'h09;
    localparam logic [CMD_W-1:0] C_BULK_DATA = 6'h0B;
    localparam logic [CMD_W-1:0] C_BEGIN_W   = 6'h18;

    typedef enum logic [3:0] {
        K_NONE, K_KEEP, K_LD_CFG, K_LD_PROG, K_LD_DATA,
        K_BEGIN_EW, K_BEGIN_W, K_BULK_PROG, K_BULK_DATA,
        K_UNLK_A, K_UNLK_B
    } cmd_kind_e;

    typedef enum logic [1:0] {PH_IDLE, PH_ERASE, PH_WRITE} phase_e;

    typedef enum logic [1:0] {
        SC_WORD = 2'd0, SC_ARRAY = 2'd1, SC_ARRAY_TEST = 2'd2, SC_CHIP = 2'd3
    } scope_e;

    typedef enum logic [1:0] {ARM_NONE, ARM_PROG, ARM_PROG_TEST, ARM_DATA} arm_e;

    typedef enum logic [1:0] {LT_PROG, LT_CFG, LT_DATA} ld_tgt_e;

    typedef enum logic [2:0] {UL_IDLE, UL_A1, UL_B1, UL_RUN, UL_A2} unlock_e;

endpackage

// File: rtl/nvseq_cmd_decode.sv
`timescale 1ns/1ps
module nvseq_cmd_decode
    import nvseq_pkg::*;
(
    input  logic [CMD_W-1:0] code,
    output cmd_kind_e        kind
);
    always_comb begin
        case (code)
            C_LD_CFG:    kind = K_LD_CFG;
            C_LD_PROG:   kind = K_LD_PROG;
            C_LD_DATA:   kind = K_LD_DATA;
            C_RD_PROG,
            C_RD_DATA,
            C_INC:       kind = K_KEEP;
            C_BEGIN_EW:  kind = K_BEGIN_EW;
            C_BEGIN_W:   kind = K_BEGIN_W;
            C_BULK_PROG: kind = K_BULK_PROG;
            C_BULK_DATA: kind = K_BULK_DATA;
            C_UNLK_A:    kind = K_UNLK_A;
            C_UNLK_B:    kind = K_UNLK_B;
            default:     kind = K_NONE;
        endcase
    end
endmodule

// File: rtl/nvseq_addr_class.sv
`timescale 1ns/1ps
module nvseq_addr_class #(
    parameter int ADDR_W    = 14,
    parameter int TEST_SPAN = 16,
    parameter int CFG_OFS   = 7
) (
    input  logic [ADDR_W-1:0] addr,
    output logic              in_cfg,
    output logic              in_test,
    output logic              is_cfg_word
);
    localparam int OFS_W = ADDR_W - 1;
    localparam logic [OFS_W-1:0] SPAN_LIM = OFS_W'(TEST_SPAN);
    localparam logic [OFS_W-1:0] CFG_POS  = OFS_W'(CFG_OFS);

    always_comb begin
        in_cfg      = addr[ADDR_W-1];
        in_test     = in_cfg && (addr[OFS_W-1:0] < SPAN_LIM);
        is_cfg_word = in_cfg && (addr[OFS_W-1:0] == CFG_POS);
    end
endmodule

// File: rtl/nvseq_cycle_timer.sv
`timescale 1ns/1ps
module nvseq_cycle_timer #(
    parameter int TICKS = 1000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    output logic done
);
    localparam int CNT_W = (TICKS > 1) ? $clog2(TICKS + 1) : 1;
    localparam logic [CNT_W-1:0] LAST = CNT_W'(TICKS - 1);

    logic [CNT_W-1:0] count_d, count_q;

    always_comb begin
        done    = run && (count_q == LAST);
        count_d = count_q;
        if (!run || done) begin
            count_d = '0;
        end else begin
            count_d = count_q + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) count_q <= '0;
        else        count_q <= count_d;
    end
endmodule

// File: rtl/nv_prog_sequencer.sv
`timescale 1ns/1ps
module nv_prog_sequencer
    import nvseq_pkg::*;
#(
    parameter int CLK_HZ    = 100_000_000,
    parameter int CYCLE_US  = 10_000,
    parameter int ADDR_W    = 14,
    parameter int DATA_W    = 14,
    parameter int DATA_AW   = 6,
    parameter int DATA_BITS = 8,
    parameter int CP_LSB    = 4,
    parameter int TEST_SPAN = 16,
    parameter int CFG_OFS   = 7
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 cmd_valid,
    input  logic [CMD_W-1:0]     cmd_code,
    input  logic [DATA_W-1:0]    cmd_data,
    input  logic [ADDR_W-1:0]    cur_addr,
    output logic                 busy,
    output logic                 erase_en,
    output logic                 write_en,
    output logic                 mem_is_data,
    output logic [1:0]           erase_scope,
    output logic [ADDR_W-1:0]    nv_addr,
    output logic [DATA_W-1:0]    nv_wdata,
    output logic                 protected_o
);
    localparam int TICKS = (CLK_HZ / 1_000_000) * CYCLE_US;

    typedef struct packed {
        phase_e              phase;
        logic                do_write;
        scope_e              scope;
        logic                is_data;
        logic                cfg_hit;
        logic [ADDR_W-1:0]   addr;
        logic [DATA_W-1:0]   wdata;
        logic                ld_valid;
        ld_tgt_e             ld_tgt;
        logic [DATA_W-1:0]   ld_word;
        arm_e                arm;
        logic                prot;
        unlock_e             step;
    } st_t;

    st_t d, q;

    cmd_kind_e kind;
    logic      in_cfg, in_test, is_cfg_word;
    logic      t_done;

    nvseq_cmd_decode u_dec (
        .code (cmd_code),
        .kind (kind)
    );

    nvseq_addr_class #(
        .ADDR_W    (ADDR_W),
        .TEST_SPAN (TEST_SPAN),
        .CFG_OFS   (CFG_OFS)
    ) u_cls (
        .addr        (cur_addr),
        .in_cfg      (in_cfg),
        .in_test     (in_test),
        .is_cfg_word (is_cfg_word)
    );

    nvseq_cycle_timer #(
        .TICKS (TICKS)
    ) u_tmr (
        .clk   (clk),
        .rst_n (rst_n),
        .run   (q.phase != PH_IDLE),
        .done  (t_done)
    );

    logic                tgt_data;
    logic                wr_blocked;
    logic [ADDR_W-1:0]   data_addr;
    logic [DATA_W-1:0]   data_word;

    always_comb begin
        tgt_data   = (q.ld_tgt == LT_DATA);
        wr_blocked = q.prot && (tgt_data || !in_cfg);
        data_addr  = {{(ADDR_W-DATA_AW){1'b0}}, cur_addr[DATA_AW-1:0]};
        data_word  = {{(DATA_W-DATA_BITS){1'b0}}, q.ld_word[DATA_BITS-1:0]};
    end

    always_comb begin
        d = q;
        if (q.phase != PH_IDLE) begin
            if (t_done) begin
                if (q.phase == PH_ERASE && q.do_write) begin
                    d.phase = PH_WRITE;
                end else begin
                    d.phase = PH_IDLE;
                    if (q.phase == PH_WRITE && q.cfg_hit) begin
                        d.prot = ~&q.wdata[DATA_W-1:CP_LSB];
                    end
                end
            end
        end else if (cmd_valid) begin
            case (kind)
                K_LD_CFG, K_LD_PROG, K_LD_DATA: begin
                    d.ld_valid = 1'b1;
                    d.ld_word  = cmd_data;
                    d.ld_tgt   = (kind == K_LD_DATA) ? LT_DATA :
                                 (kind == K_LD_CFG)  ? LT_CFG  : LT_PROG;
                    d.step     = UL_IDLE;
                end
                K_BULK_PROG: begin
                    if (!q.prot) d.arm = in_test ? ARM_PROG_TEST : ARM_PROG;
                    d.step = UL_IDLE;
                end
                K_BULK_DATA: begin
                    if (!q.prot) d.arm = ARM_DATA;
                    d.step = UL_IDLE;
                end
                K_UNLK_A: begin
                    if (q.step == UL_IDLE && q.ld_valid && q.ld_tgt == LT_CFG &&
                        q.ld_word[CP_LSB] && is_cfg_word) begin
                        d.step = UL_A1;
                    end else if (q.step == UL_RUN) begin
                        d.step = UL_A2;
                    end else begin
                        d.step = UL_IDLE;
                    end
                end
                K_UNLK_B: begin
                    if (q.step == UL_A1) begin
                        d.step = UL_B1;
                    end else if (q.step == UL_A2) begin
                        d.prot = 1'b0;
                        d.step = UL_IDLE;
                    end else begin
                        d.step = UL_IDLE;
                    end
                end
                K_BEGIN_EW, K_BEGIN_W: begin
                    d.step = UL_IDLE;
                    if (q.ld_valid) begin
                        if (q.step == UL_B1) begin
                            d.phase    = PH_ERASE;
                            d.do_write = 1'b0;
                            d.scope    = SC_CHIP;
                            d.is_data  = 1'b0;
                            d.cfg_hit  = 1'b0;
                            d.addr     = cur_addr;
                            d.wdata    = '1;
                            d.ld_valid = 1'b0;
                            d.arm      = ARM_NONE;
                            d.step     = UL_RUN;
                        end else if (q.arm != ARM_NONE) begin
                            d.phase    = PH_ERASE;
                            d.do_write = 1'b0;
                            d.scope    = (q.arm == ARM_PROG_TEST) ? SC_ARRAY_TEST : SC_ARRAY;
                            d.is_data  = (q.arm == ARM_DATA);
                            d.cfg_hit  = 1'b0;
                            d.addr     = (q.arm == ARM_DATA) ? data_addr : cur_addr;
                            d.wdata    = '1;
                            d.ld_valid = 1'b0;
                            d.arm      = ARM_NONE;
                        end else if (!wr_blocked) begin
                            d.phase    = (kind == K_BEGIN_EW) ? PH_ERASE : PH_WRITE;
                            d.do_write = 1'b1;
                            d.scope    = SC_WORD;
                            d.is_data  = tgt_data;
                            d.cfg_hit  = !tgt_data && is_cfg_word;
                            d.addr     = tgt_data ? data_addr : cur_addr;
                            d.wdata    = tgt_data ? data_word : q.ld_word;
                            d.ld_valid = 1'b0;
                        end
                    end
                end
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    always_comb begin
        busy        = (q.phase != PH_IDLE);
        erase_en    = (q.phase == PH_ERASE);
        write_en    = (q.phase == PH_WRITE);
        mem_is_data = q.is_data;
        erase_scope = q.scope;
        nv_addr     = q.addr;
        nv_wdata    = q.wdata;
        protected_o = q.prot;
    end
endmodule

// File: rtl/nv_prog_sequencer_chk.sv
`timescale 1ns/1ps
module nv_prog_sequencer_chk #(
    parameter int TICKS     = 1000,
    parameter int ADDR_W    = 14,
    parameter int DATA_W    = 14,
    parameter int DATA_AW   = 6,
    parameter int DATA_BITS = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic              cmd_valid,
    input logic              busy,
    input logic              erase_en,
    input logic              write_en,
    input logic              mem_is_data,
    input logic [1:0]        erase_scope,
    input logic [ADDR_W-1:0] nv_addr,
    input logic [DATA_W-1:0] nv_wdata,
    input logic              protected_o
);
    int er_run, wr_run;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            er_run <= 0;
            wr_run <= 0;
        end else begin
            er_run <= erase_en ? er_run + 1 : 0;
            wr_run <= write_en ? wr_run + 1 : 0;
        end
    end

    assert_one_phase_R3: assert property (@(posedge clk) disable iff (!rst_n)
        !(erase_en && write_en));

    assert_busy_has_phase_R3: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> (erase_en || write_en));

    assert_erase_len_R3: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(erase_en) |-> (er_run == TICKS));

    assert_write_len_R4: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(write_en) |-> (wr_run == TICKS));

    assert_op_stable_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && $past(busy)) |-> ($stable(nv_addr) && $stable(nv_wdata) &&
                                   $stable(erase_scope) && $stable(mem_is_data)));

    assert_data_byte_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (write_en && mem_is_data) |->
            (nv_wdata[DATA_W-1:DATA_BITS] == '0 && nv_addr[ADDR_W-1:DATA_AW] == '0));

    assert_bulk_no_write_R6: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(erase_en) && erase_scope != 2'd0) |-> !write_en);

    assert_prot_cause_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(protected_o) |-> ($past(write_en) || $past(cmd_valid)));
endmodule

bind nv_prog_sequencer nv_prog_sequencer_chk #(
    .TICKS     (TICKS),
    .ADDR_W    (ADDR_W),
    .DATA_W    (DATA_W),
    .DATA_AW   (DATA_AW),
    .DATA_BITS (DATA_BITS)
) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .cmd_valid   (cmd_valid),
    .busy        (busy),
    .erase_en    (erase_en),
    .write_en    (write_en),
    .mem_is_data (mem_is_data),
    .erase_scope (erase_scope),
    .nv_addr     (nv_addr),
    .nv_wdata    (nv_wdata),
    .protected_o (protected_o)
);

// File: tb/test_nv_prog_sequencer.sv
`timescale 1ns/1ps
module test_nv_prog_sequencer;
    localparam int T = 8;

    localparam logic [5:0] LDC = 6'h00, LDP = 6'h02, LDD = 6'h03, INC = 6'h06;
    localparam logic [5:0] BEW = 6'h08, BW = 6'h18, BKP = 6'h09, BKD = 6'h0B;
    localparam logic [5:0] UA = 6'h01, UB = 6'h07;

    logic        clk = 0;
    logic        rst_n = 0;
    logic        cmd_valid = 0;
    logic [5:0]  cmd_code = 0;
    logic [13:0] cmd_data = 0;
    logic [13:0] cur_addr = 0;
    logic        busy, erase_en, write_en, mem_is_data, protected_o;
    logic [1:0]  erase_scope;
    logic [13:0] nv_addr, nv_wdata;

    always #5 clk = ~clk;

    nv_prog_sequencer #(.CLK_HZ(1_000_000), .CYCLE_US(T)) i_nv_prog_sequencer (
        .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_code(cmd_code),
        .cmd_data(cmd_data), .cur_addr(cur_addr), .busy(busy), .erase_en(erase_en),
        .write_en(write_en), .mem_is_data(mem_is_data), .erase_scope(erase_scope),
        .nv_addr(nv_addr), .nv_wdata(nv_wdata), .protected_o(protected_o)
    );

    int n_chk = 0, n_bad = 0;
    bit finished = 0;

    int er_n = 0, wr_n = 0;
    logic [1:0]  last_scope = 0;
    logic        last_er_data = 0;
    logic [13:0] last_wa = 0, last_wd = 0;
    logic        last_wisd = 0;

    always @(negedge clk) begin
        if (erase_en) begin
            er_n++;
            last_scope   = erase_scope;
            last_er_data = mem_is_data;
        end
        if (write_en) begin
            wr_n++;
            last_wa   = nv_addr;
            last_wd   = nv_wdata;
            last_wisd = mem_is_data;
        end
    end

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
        end
    endtask

    task automatic send(input logic [5:0] c, input logic [13:0] dt);
        @(negedge clk);
        cmd_valid = 1; cmd_code = c; cmd_data = dt;
        @(negedge clk);
        cmd_valid = 0;
    endtask

    task automatic wait_idle();
        for (int n = 0; n < 1000 && busy; n++) @(negedge clk);
    endtask

    task automatic clear_mon();
        er_n = 0; wr_n = 0;
    endtask

    task automatic op(input logic [5:0] ld, input logic [13:0] dt,
                      input logic [13:0] adr, input logic [5:0] bg);
        cur_addr = adr;
        send(ld, dt);
        clear_mon();
        send(bg, 14'h0);
        wait_idle();
        repeat (2) @(negedge clk);
    endtask

    typedef struct packed {
        logic [5:0]  ld;
        logic [13:0] dat;
        logic [13:0] adr;
        logic [5:0]  bg;
        logic        er;
        logic [13:0] exp_d;
        logic [13:0] exp_a;
        logic        is_d;
    } vec_t;

    localparam vec_t VECS [0:4] = '{
        '{6'h02, 14'h1234, 14'h0005, 6'h08, 1'b1, 14'h1234, 14'h0005, 1'b0}, // R3
        '{6'h02, 14'h0ABC, 14'h03FF, 6'h18, 1'b0, 14'h0ABC, 14'h03FF, 1'b0}, // R4
        '{6'h03, 14'h3A5C, 14'h0047, 6'h08, 1'b1, 14'h005C, 14'h0007, 1'b1}, // R5
        '{6'h00, 14'h0F0F, 14'h2001, 6'h18, 1'b0, 14'h0F0F, 14'h2001, 1'b0}, // R4
        '{6'h03, 14'h00FF, 14'h003F, 6'h18, 1'b0, 14'h00FF, 14'h003F, 1'b1}  // R5
    };

    initial begin
        #1_000_000;
        if (!finished) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog expired actual=1 expected=0");
            $display("test done: total=%0d bad=%0d", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        check(busy == 0 && erase_en == 0 && write_en == 0, "R1 idle after reset",
              {busy, erase_en, write_en}, 0);
        check(protected_o == 0, "R1 protection clear", protected_o, 0);
        rst_n = 1;
        repeat (2) @(negedge clk);

        // R2: begin with no preceding load
        clear_mon();
        send(BEW, 14'h0);
        repeat (4) @(negedge clk);
        check(er_n + wr_n == 0, "R2 begin without load", er_n + wr_n, 0);

        // R3 R4 R5 table
        foreach (VECS[i]) begin
            op(VECS[i].ld, VECS[i].dat, VECS[i].adr, VECS[i].bg);
            check(er_n == (VECS[i].er ? T : 0), $sformatf("R3 row %0d erase cycles", i),
                  er_n, VECS[i].er ? T : 0);
            check(wr_n == T, $sformatf("R4 row %0d write cycles", i), wr_n, T);
            check(last_wd == VECS[i].exp_d, $sformatf("R5 row %0d data", i),
                  last_wd, VECS[i].exp_d);
            check(last_wa == VECS[i].exp_a && last_wisd == VECS[i].is_d,
                  $sformatf("R5 row %0d addr/target", i), last_wa, VECS[i].exp_a);
        end

        // R2: load consumed by the previous begin
        clear_mon();
        send(BW, 14'h0);
        repeat (4) @(negedge clk);
        check(er_n + wr_n == 0, "R2 second begin ignored", er_n + wr_n, 0);

        // R6: bulk data erase armed, then executed, then consumed
        cur_addr = 14'h0010;
        send(BKD, 14'h0);
        op(LDD, 14'h3FFF, 14'h0010, BEW);
        check(er_n == T && wr_n == 0, "R6 bulk erase only", {er_n[15:0], wr_n[15:0]}, T << 16);
        check(last_scope == 2'd1 && last_er_data == 1, "R6 bulk data scope",
              {last_scope, last_er_data}, 3);
        op(LDD, 14'h0011, 14'h0002, BW);
        check(wr_n == T && er_n == 0 && last_wd == 14'h0011, "R6 arm consumed", wr_n, T);

        // R7: program bulk erase inside the test window and outside it
        cur_addr = 14'h2004;
        send(BKP, 14'h0);
        op(LDC, 14'h3FFF, 14'h2004, BEW);
        check(last_scope == 2'd2 && er_n == T && wr_n == 0, "R7 user+test scope", last_scope, 2);
        cur_addr = 14'h0100;
        send(BKP, 14'h0);
        op(LDP, 14'h3FFF, 14'h0100, BEW);
        check(last_scope == 2'd1 && last_er_data == 0, "R7 user-only scope", last_scope, 1);

        // R12: commands during busy are dropped
        cur_addr = 14'h0003;
        send(LDP, 14'h0042);
        send(BEW, 14'h0);
        send(BKD, 14'h0);
        send(LDD, 14'h0077);
        wait_idle();
        clear_mon();
        send(BW, 14'h0);
        repeat (4) @(negedge clk);
        check(er_n + wr_n == 0, "R12 load during busy dropped", er_n + wr_n, 0);
        op(LDP, 14'h0155, 14'h0004, BEW);
        check(last_scope == 2'd0 && wr_n == T, "R12 bulk during busy dropped", last_scope, 0);

        // R8: configuration word writes
        op(LDC, 14'h3FF7, 14'h2007, BEW);
        check(protected_o == 0, "R8 all protect bits 1", protected_o, 0);
        op(LDC, 14'h3FEF, 14'h2007, BW);
        check(protected_o == 1, "R8 bit 4 cleared protects", protected_o, 1);

        // R9: bulk erase ignored when protected; ID write still done (R10)
        cur_addr = 14'h0000;
        send(BKP, 14'h0);
        op(LDC, 14'h3FF5, 14'h2002, BEW);
        check(last_scope == 2'd0 && er_n == T && wr_n == T, "R9 bulk ignored", last_scope, 0);
        check(last_wd == 14'h3FF5 && last_wa == 14'h2002, "R10 ID write allowed", last_wd, 14'h3FF5);

        // R10: user and data writes blocked
        op(LDP, 14'h0123, 14'h0010, BEW);
        check(er_n + wr_n == 0, "R10 program write blocked", er_n + wr_n, 0);
        op(LDD, 14'h0023, 14'h0010, BW);
        check(er_n + wr_n == 0, "R10 data write blocked", er_n + wr_n, 0);

        // R11: unlock handshake
        cur_addr = 14'h2000;
        send(LDC, 14'h0010);
        send(INC, 14'h0);
        cur_addr = 14'h2007;
        send(UA, 14'h0);
        send(UB, 14'h0);
        clear_mon();
        send(BEW, 14'h0);
        wait_idle();
        repeat (2) @(negedge clk);
        check(er_n == T && wr_n == 0 && last_scope == 2'd3, "R11 chip clear erase",
              last_scope, 3);
        check(protected_o == 1, "R11 protection held until second pair", protected_o, 1);
        send(UA, 14'h0);
        send(UB, 14'h0);
        @(negedge clk);
        check(protected_o == 0, "R11 protection cleared", protected_o, 0);
        op(LDP, 14'h0321, 14'h0010, BW);
        check(wr_n == T && last_wd == 14'h0321, "R11 user write after unlock", wr_n, T);

        finished = 1;
        $display("test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end
endmodule